// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits on the host side of an asynchronous parallel mask ROM. It turns single-cycle read requests into correctly timed sequences on the ROM's address, chip-enable, output-enable and width-select pins. Each request carries a start address, a beat count and a flag that picks 8-bit or 16-bit reads. The controller returns one response beat per byte or word. Every analog timing limit is a nanosecond parameter. The controller converts each limit into clock cycles by dividing by the clock period and rounding up.

The ROM delivers a neighbouring location much faster once a page has been opened. The controller keeps the current page open for the length of a burst. A step that stays inside the page waits only the short page delay. A step that carries into the upper address bits pays the full random-access delay. In 8-bit mode the ROM's top data pin becomes its lowest address input, so the controller drives that pin itself. In 16-bit mode it leaves the pin to the ROM. Between bursts the chip is put in standby and the page is forgotten. After reset the chip enable is held inactive for the power-up settling time.

Top module: `prom_page_reader`

## Requirements
- R1: After reset is released, `busy` stays high and `rom_ce_n` stays high for exactly ceil(200 ns / clock period) cycles, which is 10 cycles at 50 MHz. A request made during that time is never served.
- R2: The first beat of a burst has `rsp_valid` high exactly FULL cycles after the edge that accepted the request. FULL is the largest of the rounded-up address, chip-enable and output-enable access times, which is 5 cycles by default. If the width flag differs from the previous burst, the largest of FULL and the rounded-up mode-switch time is used instead.
- R3: A beat whose address lies in the same page as the previous beat follows it by exactly PAGE cycles. PAGE is ceil(25 ns / clock period), which is 2 by default.
- R4: The page is the low PAGE_WORD_BITS bits of the word address (2 bits by default) in 16-bit mode, and those bits plus the byte select bit (3 bits) in 8-bit mode. A beat that follows a beat whose page bits were all ones waits FULL cycles.
- R5: A request with length field L returns L+1 beats at consecutive addresses. The address wraps to zero at the top of the address space.
- R6: In 16-bit mode `rom_word` is 1, `rom_lsb_oe` is 0, `rom_addr` equals the request address bits [ADDR_W-1:0] and `rsp_data` equals `rom_dq_in[15:0]`.
- R7: In 8-bit mode `rom_word` is 0 and `rom_lsb_oe` is 1. `rom_addr` is byte address bits [ADDR_W:1] and `rom_lsb_out` is byte address bit 0. `rsp_data` is `{8'h00, rom_dq_in[7:0]}`.
- R8: `rsp_valid` is high for exactly one cycle per beat.
- R9: A request presented while `busy` is high is ignored and is not held over to be served later.
- R10: `rom_ce_n` and `rom_oe_n` go high on the same edge that raises `rsp_valid` for the last beat. `busy` then stays high for FLOAT cycles (ceil(25 ns / period), which is 2). The next request starts with the full wait.
- R11: While idle, `rom_ce_n` and `rom_oe_n` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request, taken when `busy` is low |
| req_byte | input | 1 | 1 selects 8-bit reads, 0 selects 16-bit reads |
| req_addr | input | ADDR_W+1 | Start address: byte address in 8-bit mode, word address in the low ADDR_W bits in 16-bit mode |
| req_len | input | LEN_W | Number of beats minus one |
| busy | output | 1 | High when not idle |
| rsp_valid | output | 1 | One-cycle strobe per returned beat |
| rsp_data | output | 16 | Returned word, or byte zero-extended |
| rom_addr | output | ADDR_W | ROM word address pins |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 for 16-bit |
| rom_dq_in | input | 16 | ROM data pins as seen by the host |
| rom_lsb_out | output | 1 | Byte select value for the shared top data pin |
| rom_lsb_oe | output | 1 | Drive enable for the shared top data pin |

## Verification
Two functions can land on the same clock edge. The response for the final beat of a burst coincides with the release of chip and output enable and the closing of the page. A refused request can also coincide with a beat being returned. The bench provokes the first case with every burst, and judges it by the pin levels on the cycle of the final strobe and by how long `busy` stays high afterwards. It provokes the second case by holding a conflicting request high through a whole burst. The returned data and timing must match an unpoked burst, and no extra burst may follow.

// File: rtl/prom_rd_pkg.sv
// Shared types and helpers for the page-mode ROM reader.
// Assumes all timing limits are non-negative nanosecond integers.
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_PWR   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FLOAT = 2'd3
    } rd_state_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_cycle_timer.sv
// Down-counter used for every ROM wait.
// Loads a value, counts down to zero and holds there; done is high at zero.
// Assumes load_val fits in CNT_W bits.
module prom_cycle_timer #(
    parameter int CNT_W     = 4,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    // Load a new wait or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R2

endmodule

// File: rtl/prom_addr_walker.sv
// Holds the current burst address and width mode.
// Steps the address and reports whether it sits on the last slot of its page.
// In 8-bit mode the address is a byte address. In 16-bit mode only the
// low ADDR_W bits take part and wrap.
module prom_addr_walker #(
    parameter int ADDR_W    = 22,
    parameter int PAGE_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   start_addr,
    input  logic              start_byte,
    input  logic              step,
    output logic [ADDR_W:0]   cur,
    output logic              byte_mode,
    output logic              page_last,
    output logic [ADDR_W-1:0] word_addr,
    output logic              lsb
);

    // Capture a new burst or advance by one beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            byte_mode <= 1'b0;
        end else if (start) begin
            cur       <= start_addr;
            byte_mode <= start_byte;
        end else if (step) begin
            if (byte_mode) begin
                cur <= cur + 1'b1;
            end else begin
                cur[ADDR_W-1:0] <= cur[ADDR_W-1:0] + 1'b1;
            end
        end
    end

    // The page field is one bit wider in byte mode.
    always_comb begin
        if (byte_mode) begin
            page_last = &cur[PAGE_BITS:0];
            word_addr = cur[ADDR_W:1];
        end else begin
            page_last = &cur[PAGE_BITS-1:0];
            word_addr = cur[ADDR_W-1:0];
        end
    end

    assign lsb = cur[0];

    AST_WORD_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && !byte_mode && page_last) |=> (cur[PAGE_BITS-1:0] == '0)); // R4

    AST_BYTE_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && byte_mode && page_last) |=> (cur[PAGE_BITS:0] == '0)); // R4

endmodule

// File: rtl/prom_page_reader.sv
// Synchronous read controller for an asynchronous page-mode mask ROM.
// Holds chip enable off through power-up, then serves bursts. The first
// beat pays the full access wait; in-page beats pay the page wait; page
// crossings pay the full wait again. Standby and a closed page between
// bursts. Assumes the ROM data pins are captured directly by clk and that
// an outer pad drives the shared top data pin from rom_lsb_out/rom_lsb_oe.
module prom_page_reader
    import prom_rd_pkg::*;
#(
    parameter int CLK_NS         = 20,
    parameter int ADDR_W         = 22,
    parameter int PAGE_WORD_BITS = 2,
    parameter int LEN_W          = 8,
    parameter int T_PWR_NS       = 200,
    parameter int T_ACC_NS       = 100,
    parameter int T_CE_NS        = 100,
    parameter int T_OE_NS        = 25,
    parameter int T_PAGE_NS      = 25,
    parameter int T_MODE_NS      = 100,
    parameter int T_FLOAT_NS     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_byte,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_word,
    input  logic [15:0]       rom_dq_in,
    output logic              rom_lsb_out,
    output logic              rom_lsb_oe
);

    localparam int PWR_CYC   = max2(1, ns_to_cyc(T_PWR_NS, CLK_NS));
    localparam int FULL_CYC  = max2(1, max2(ns_to_cyc(T_ACC_NS, CLK_NS),
                                     max2(ns_to_cyc(T_CE_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS))));
    localparam int MODE_CYC  = max2(FULL_CYC, ns_to_cyc(T_MODE_NS, CLK_NS));
    localparam int PAGE_CYC  = max2(1, ns_to_cyc(T_PAGE_NS, CLK_NS));
    localparam int FLOAT_CYC = ns_to_cyc(T_FLOAT_NS, CLK_NS);
    localparam int MAX_CYC   = max2(max2(PWR_CYC, MODE_CYC), max2(PAGE_CYC, FLOAT_CYC));
    localparam int TMR_W     = $clog2(MAX_CYC + 1);

    localparam logic [TMR_W-1:0] LD_FULL  = TMR_W'(FULL_CYC - 1);
    localparam logic [TMR_W-1:0] LD_MODE  = TMR_W'(MODE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_PAGE  = TMR_W'(PAGE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_FLOAT = TMR_W'(FLOAT_CYC);

    rd_state_e         state_q;
    logic [LEN_W-1:0]  remain_q;
    logic              ce_n_q;
    logic              oe_n_q;
    logic              rsp_valid_q;
    logic [15:0]       rsp_data_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_done;

    logic [ADDR_W:0]   walk_cur;
    logic              byte_q;
    logic              page_last;
    logic              walk_lsb;
    logic [ADDR_W-1:0] walk_word;

    logic              accept;
    logic              beat_done;
    logic              last_beat;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign beat_done = (state_q == ST_WAIT) && tmr_done;
    assign last_beat = beat_done && (remain_q == '0);

    prom_cycle_timer #(
        .CNT_W     (TMR_W),
        .RESET_VAL (PWR_CYC)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .done     (tmr_done)
    );

    prom_addr_walker #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_WORD_BITS)
    ) i_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_addr (req_addr),
        .start_byte (req_byte),
        .step       (beat_done && !last_beat),
        .cur        (walk_cur),
        .byte_mode  (byte_q),
        .page_last  (page_last),
        .word_addr  (walk_word),
        .lsb        (walk_lsb)
    );

    // Pick which wait to start: full, mode-switch, page or bus release.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = (req_byte != byte_q) ? LD_MODE : LD_FULL;
        end else if (last_beat) begin
            tmr_load = 1'b1;
            tmr_val  = LD_FLOAT;
        end else if (beat_done) begin
            tmr_load = 1'b1;
            tmr_val  = page_last ? LD_FULL : LD_PAGE;
        end
    end

    // Sequence power-up hold, idle, read waits and bus release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR;
        end else begin
            case (state_q)
                ST_PWR:   if (tmr_done)  state_q <= ST_IDLE;
                ST_IDLE:  if (req_valid) state_q <= ST_WAIT;
                ST_WAIT:  if (last_beat) state_q <= ST_FLOAT;
                ST_FLOAT: if (tmr_done)  state_q <= ST_IDLE;
                default:                 state_q <= ST_PWR;
            endcase
        end
    end

    // Enable the chip for a burst and return it to standby after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            oe_n_q <= 1'b1;
        end else if (accept) begin
            ce_n_q <= 1'b0;
            oe_n_q <= 1'b0;
        end else if (last_beat) begin
            ce_n_q <= 1'b1;
            oe_n_q <= 1'b1;
        end
    end

    // Count the beats still owed in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (accept) begin
            remain_q <= req_len;
        end else if (beat_done && !last_beat) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Capture the ROM data when its wait has run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= beat_done;
            if (beat_done) begin
                rsp_data_q <= byte_q ? {8'h00, rom_dq_in[7:0]} : rom_dq_in;
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign rom_addr    = walk_word;
    assign rom_ce_n    = ce_n_q;
    assign rom_oe_n    = oe_n_q;
    assign rom_word    = !byte_q;
    assign rom_lsb_out = walk_lsb;
    assign rom_lsb_oe  = byte_q;

    AST_PWR_CE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWR) |-> (rom_ce_n && busy)); // R1

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (rom_ce_n && rom_oe_n)); // R11

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !tmr_done) |=> $stable(walk_cur)); // R9

    AST_INPAGE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && remain_q != '0 && !page_last) |=> (tmr_cnt == LD_PAGE)); // R3

    AST_CROSS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && remain_q != '0 && page_last) |=> (tmr_cnt == LD_FULL)); // R4

    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && byte_q) |-> (rsp_data[15:8] == 8'h00)); // R7

    AST_RSP_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!rom_ce_n)); // R8

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state_q == ST_FLOAT) |-> (rom_ce_n && rom_oe_n)); // R10

endmodule

// File: tb/test_prom_page_reader.sv
// Bench for prom_page_reader: vector table of bursts, then directed cases.
module test_prom_page_reader;

    localparam int CLKP  = 20;
    localparam int PWR   = 10;
    localparam int FULL  = 5;
    localparam int MODE  = 5;
    localparam int PAGE  = 2;
    localparam int FLOAT = 2;
    localparam int NV    = 7;

    localparam logic [22:0] V_ADDR [NV] = '{23'h000010, 23'h000021, 23'h000005, 23'h00000E,
                                            23'h3FFFFE, 23'h7FFFFB, 23'h000100};
    localparam int          V_LEN  [NV] = '{0, 5, 4, 3, 2, 6, 9};
    localparam bit          V_BYTE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_XING [NV] = '{0, 1, 1, 1, 1, 1, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_byte = 1'b0;
    logic [22:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        busy, rsp_valid, rom_ce_n, rom_oe_n, rom_word, rom_lsb_out, rom_lsb_oe;
    logic [15:0] rsp_data;
    logic [21:0] rom_addr;
    logic [15:0] rom_dq_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit last_byte = 1'b0;

    always #(CLKP/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prom_page_reader i_prom_page_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_byte    (req_byte),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rom_addr    (rom_addr),
        .rom_ce_n    (rom_ce_n),
        .rom_oe_n    (rom_oe_n),
        .rom_word    (rom_word),
        .rom_dq_in   (rom_dq_in),
        .rom_lsb_out (rom_lsb_out),
        .rom_lsb_oe  (rom_lsb_oe)
    );

    // ROM contents: a fixed scramble of the word address.
    function automatic logic [15:0] wv(input logic [21:0] w);
        return (w[15:0] ^ 16'h5A3C) + {10'h0, w[21:16]};
    endfunction

    function automatic logic [15:0] exp_data(input bit b, input logic [22:0] a);
        logic [15:0] w;
        w = wv(b ? a[22:1] : a[21:0]);
        if (b) return {8'h00, a[0] ? w[15:8] : w[7:0]};
        return w;
    endfunction

    function automatic bit pg_last(input bit b, input logic [22:0] a);
        return b ? (&a[2:0]) : (&a[1:0]);
    endfunction

    // ROM model: data is only valid once upper and page pins have settled long enough.
    logic [22:0] full_key, full_prev = '0;
    logic [2:0]  page_key, page_prev = '0;
    int full_age = 0, page_age = 0;
    assign full_key = {rom_addr[21:2], rom_ce_n, rom_oe_n, rom_word};
    assign page_key = {rom_addr[1:0], rom_lsb_out};
    always @(negedge clk) begin
        full_age  <= (full_key !== full_prev) ? 1 : ((full_age < 1000) ? full_age + 1 : full_age);
        page_age  <= (page_key !== page_prev) ? 1 : ((page_age < 1000) ? page_age + 1 : page_age);
        full_prev <= full_key;
        page_prev <= page_key;
    end
    always_comb begin
        logic [15:0] w;
        w = wv(rom_addr);
        if (rom_ce_n || rom_oe_n)                  rom_dq_in = 16'hFFFF;
        else if (full_age < FULL || page_age < PAGE) rom_dq_in = 16'hDEAD;
        else if (rom_word)                          rom_dq_in = w;
        else rom_dq_in = {rom_lsb_out, 7'h55, rom_lsb_out ? w[15:8] : w[7:0]};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one burst and check every beat's timing, data and pins.
    task automatic run_burst(input bit b, input logic [22:0] a, input int len,
                             input int xing_exp, input bit poke);
        int t0, tprev, gap, exp_gap, xing, n;
        logic [22:0] cur, prev;
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_byte = b; req_addr = a; req_len = 8'(len);
        @(negedge clk);
        t0 = cyc;
        if (poke) begin
            req_byte = !b; req_addr = 23'h000055; req_len = 8'd3;
        end else begin
            req_valid = 1'b0;
        end
        cur = a; prev = a; tprev = t0; xing = 0;
        for (int i = 0; i <= len; i++) begin
            exp_gap = (i == 0) ? ((b != last_byte) ? MODE : FULL) : (pg_last(b, prev) ? FULL : PAGE);
            n = 0;
            do begin @(negedge clk); n++; end while (!rsp_valid && n < 100);
            gap = cyc - tprev;
            if (i == 0) chk(gap == exp_gap, "R2 first-beat wait", gap, exp_gap);
            else if (exp_gap == FULL) chk(gap == exp_gap, "R4 page-cross wait / R8 single strobe", gap, exp_gap);
            else chk(gap == exp_gap, "R3 in-page wait / R8 single strobe", gap, exp_gap);
            if (i > 0 && gap == FULL) xing++;
            chk(rsp_data == exp_data(b, cur), b ? "R7 byte data" : "R6 word data", rsp_data, exp_data(b, cur));
            chk(rom_word == !b && rom_lsb_oe == b, b ? "R7 byte pins" : "R6 word pins",
                {rom_word, rom_lsb_oe}, {!b, b});
            tprev = cyc; prev = cur;
            cur = b ? cur + 1'b1 : {1'b0, cur[21:0] + 22'd1};
        end
        req_valid = 1'b0;
        chk(rom_ce_n && rom_oe_n && busy, "R10 release with last beat", {rom_ce_n, rom_oe_n, busy}, 3'b111);
        n = 0;
        @(negedge clk);
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk(n == FLOAT, "R10 float hold", n, FLOAT);
        chk(xing == xing_exp, "R5 beat walk page crossings", xing, xing_exp);
        last_byte = b;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLKP * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        bit ce_ok;
        bit seen;
        // Reset state (R1, R11)
        repeat (3) @(negedge clk);
        chk(rom_ce_n && rom_oe_n && !rsp_valid && busy, "R1 reset state",
            {rom_ce_n, rom_oe_n, rsp_valid, busy}, 4'b1101);
        rst_n = 1'b1;
        req_valid = 1'b1; req_byte = 1'b0; req_addr = 23'h000003; req_len = 8'd0;
        n = 0; ce_ok = 1'b1;
        do begin
            @(negedge clk);
            if (busy) n++;
            if (!rom_ce_n) ce_ok = 1'b0;
            if (n == 5) req_valid = 1'b0;
        end while (busy && n < 100);
        chk(n == PWR, "R1 power-up hold length", n, PWR);
        chk(ce_ok, "R1 chip enable held off", ce_ok, 1);
        seen = 1'b0;
        repeat (15) begin @(negedge clk); if (rsp_valid || !rom_ce_n) seen = 1'b1; end
        chk(!seen, "R1 power-up request dropped", seen, 0);
        chk(rom_ce_n && rom_oe_n, "R11 idle standby", {rom_ce_n, rom_oe_n}, 2'b11);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            run_burst(V_BYTE[v], V_ADDR[v], V_LEN[v], V_XING[v], 1'b0);
        end

        // R10: same-page request after idle pays the full wait again
        run_burst(1'b0, 23'h000011, 0, 0, 1'b0);
        run_burst(1'b0, 23'h000012, 0, 0, 1'b0);

        // R9: request held high during a burst is ignored and not queued
        run_burst(1'b1, 23'h000030, 5, 0, 1'b1);
        seen = 1'b0;
        repeat (20) begin @(negedge clk); if (rsp_valid || !rom_ce_n || busy) seen = 1'b1; end
        chk(!seen, "R9 busy request not queued", seen, 0);
        chk(rom_ce_n && rom_oe_n, "R11 idle standby after burst", {rom_ce_n, rom_oe_n}, 2'b11);

        // Mode switch back to word after byte, crossing at once (R2, R4)
        run_burst(1'b0, 23'h000007, 1, 1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule